// File: doc/BRIEF.md
# Fixed-Stream I2C Target

This block is an I2C-compatible bus target for a keypad-style peripheral. A system clock oversamples the bus, which runs at standard or fast rate (SCL up to 400 kHz). SDA is open-drain: the block never drives a high level. It only asserts a pull-low enable, and SCL is an input alone. The 7-bit bus address has two parts: a fixed prefix set by a parameter, and two low bits taken from strap pins.

There is no register pointer. A write transaction carries one data byte, and that byte loads the 8-bit control register. Bytes written after it are refused. A read transaction always returns the same four-byte stream, most significant bit first: the chip identifier, the control register, the key type, and then the key duration byte, whose top bit is the overflow flag. The key type and duration come from an external event-capture block. This block sends that block a one-cycle pulse once the duration byte has been shifted out completely, so that the capture block can retire the event.

Top module: `kpi2c_target`

## Requirements
- R1: The address byte is compared as bits [7:1] = {FIX_ADDR (5 bits), addr_pin[1:0]}, and bit 0 is the direction (0 = write, 1 = read). A match is acknowledged by pulling SDA low in the ninth clock. A mismatch is not acknowledged, and the target leaves SDA released until the next START.
- R2: After reset, ctrl_q is 0x00. In a write transaction, the first data byte after the address loads ctrl_q and is acknowledged.
- R3: A read transaction returns, in this order, CHIP_ID, ctrl_q, key_type and key_dur. Each byte is sent MSB first, and the controller acknowledges each byte to ask for the next.
- R4: The key duration byte is passed through unaltered, so the overflow flag appears on bit 7 and the time count on bits 6..0.
- R5: When the controller answers any read byte with a NACK, the target releases SDA and ignores further clocks until a START. Any such clocks read as ones, and no read-complete pulse is issued unless the duration byte had already been sent.
- R6: rd_done pulses high for exactly one system clock, once per transaction, when the last bit of the duration byte has been fully clocked out.
- R7: A START seen at any point, including a repeated START in the middle of a read, abandons the current transfer and restarts address matching.
- R8: Data bytes written after the control byte are not acknowledged and leave ctrl_q unchanged.
- R9: Bytes that the controller asks for beyond the fourth read as 0xFF, because SDA stays released.
- R10: A STOP returns the target to idle with SDA released.
- R11: The target begins pulling SDA low only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_pin | input | 2 | Strap pins that form the low address bits |
| key_type | input | 8 | Key type byte from the event-capture block |
| key_dur | input | 8 | Overflow flag and duration count from the event-capture block |
| ctrl_q | output | 8 | Control register |
| rd_done | output | 1 | One-cycle pulse after the duration byte has been sent |

## Verification
The hardest case to reach is a repeated START issued in the middle of a read. Once the controller acknowledges a byte, the target is already presenting the first bit of the next byte on SDA. The controller can only raise SDA to form the START if that bit is a one. The bench therefore first programs a control value with its MSB set, reads the chip identifier with an ACK, and then issues the repeated START for a write. A correct result shows that the new control value has landed, and that a later read still streams correctly from the chip identifier.

// File: rtl/kpi2c_pkg.sv
package kpi2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_WDATA,
      ST_WSKIP,
      ST_ACK,
      ST_TX,
      ST_RACK
   } tgt_st_e;

   localparam int unsigned STREAM_LEN = 4;

endpackage

// File: rtl/kpi2c_sync.sv
module kpi2c_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (STAGES < 2) begin : g_bad_stages
      $error("kpi2c_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_c;
   logic [STAGES-1:0] sda_c;
   logic              scl_p;
   logic              sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_c <= '1;
         sda_c <= '1;
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_c <= {scl_c[STAGES-2:0], scl_i};
         sda_c <= {sda_c[STAGES-2:0], sda_i};
         scl_p <= scl_c[STAGES-1];
         sda_p <= sda_c[STAGES-1];
      end
   end

   assign scl_s     = scl_c[STAGES-1];
   assign sda_s     = sda_c[STAGES-1];
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/kpi2c_stream_sel.sv
module kpi2c_stream_sel #(
   parameter int unsigned     BYTE_W  = 8,
   parameter logic [BYTE_W-1:0] CHIP_ID = 8'hC3,
   parameter int unsigned     IDX_W   = 3
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [BYTE_W-1:0] ctrl,
   input  logic [BYTE_W-1:0] key_type,
   input  logic [BYTE_W-1:0] key_dur,
   output logic [BYTE_W-1:0] tx_byte
);
   import kpi2c_pkg::*;

   if ((1 << (IDX_W - 1)) < STREAM_LEN) begin : g_bad_idx
      $error("kpi2c_stream_sel: IDX_W too small for stream length");
   end

   logic [BYTE_W-1:0] words [STREAM_LEN];

   always_comb begin
      words[0] = CHIP_ID;
      words[1] = ctrl;
      words[2] = key_type;
      words[3] = key_dur;
   end

   always_comb begin
      tx_byte = '1;
      for (int i = 0; i < STREAM_LEN; i++) begin
         if (idx == IDX_W'(i)) tx_byte = words[i];
      end
   end

endmodule

// File: rtl/kpi2c_target.sv
module kpi2c_target #(
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned PIN_W       = 2,
   parameter logic [ADDR_W-PIN_W-1:0] FIX_ADDR = 5'b10110,
   parameter int unsigned BYTE_W      = 8,
   parameter logic [BYTE_W-1:0] CHIP_ID = 8'hC3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [PIN_W-1:0]  addr_pin,
   input  logic [BYTE_W-1:0] key_type,
   input  logic [BYTE_W-1:0] key_dur,
   output logic [BYTE_W-1:0] ctrl_q,
   output logic              rd_done
);
   import kpi2c_pkg::*;

   localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
   localparam int unsigned IDX_W = $clog2(STREAM_LEN) + 1;

   if (BYTE_W != ADDR_W + 1) begin : g_bad_addr_w
      $error("kpi2c_target: address plus direction must fill one byte");
   end
   if (PIN_W >= ADDR_W) begin : g_bad_pin_w
      $error("kpi2c_target: PIN_W must be smaller than ADDR_W");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   kpi2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   tgt_st_e           st;
   tgt_st_e           ack_next;
   logic              ack_ph;
   logic [CNT_W-1:0]  bitcnt;
   logic [BYTE_W-1:0] sh;
   logic [IDX_W-1:0]  idx;
   logic [BYTE_W-1:0] tx_byte;
   logic [BYTE_W-1:0] rx_byte;
   logic              addr_hit;

   kpi2c_stream_sel #(
      .BYTE_W  (BYTE_W),
      .CHIP_ID (CHIP_ID),
      .IDX_W   (IDX_W)
   ) u_sel (
      .idx      (idx),
      .ctrl     (ctrl_q),
      .key_type (key_type),
      .key_dur  (key_dur),
      .tx_byte  (tx_byte)
   );

   assign rx_byte  = {sh[BYTE_W-2:0], sda_s};
   assign addr_hit = (rx_byte[BYTE_W-1 -: ADDR_W] == {FIX_ADDR, addr_pin});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         ack_next <= ST_IDLE;
         ack_ph   <= 1'b0;
         bitcnt   <= '0;
         sh       <= '0;
         idx      <= '0;
         ctrl_q   <= '0;
         sda_oe   <= 1'b0;
         rd_done  <= 1'b0;
      end else begin
         rd_done <= 1'b0;
         if (start_det) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_ADDR: if (scl_rise) begin
                  sh <= rx_byte;
                  if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                     if (addr_hit) begin
                        st       <= ST_ACK;
                        ack_ph   <= 1'b0;
                        idx      <= '0;
                        ack_next <= sda_s ? ST_TX : ST_WDATA;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end else begin
                     bitcnt <= bitcnt + 1'b1;
                  end
               end
               ST_WDATA: if (scl_rise) begin
                  sh <= rx_byte;
                  if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                     ctrl_q   <= rx_byte;
                     st       <= ST_ACK;
                     ack_ph   <= 1'b0;
                     ack_next <= ST_WSKIP;
                  end else begin
                     bitcnt <= bitcnt + 1'b1;
                  end
               end
               ST_WSKIP: if (scl_rise) begin
                  bitcnt <= (bitcnt == CNT_W'(BYTE_W)) ? '0 : bitcnt + 1'b1;
               end
               ST_ACK: if (scl_fall) begin
                  if (!ack_ph) begin
                     sda_oe <= 1'b1;
                     ack_ph <= 1'b1;
                  end else begin
                     st     <= ack_next;
                     bitcnt <= '0;
                     ack_ph <= 1'b0;
                     if (ack_next == ST_TX) begin
                        sh     <= tx_byte;
                        sda_oe <= ~tx_byte[BYTE_W-1];
                     end else begin
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_TX: if (scl_fall) begin
                  if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                     sda_oe  <= 1'b0;
                     st      <= ST_RACK;
                     ack_ph  <= 1'b0;
                     rd_done <= (idx == IDX_W'(STREAM_LEN - 1));
                  end else begin
                     bitcnt <= bitcnt + 1'b1;
                     sh     <= {sh[BYTE_W-2:0], 1'b1};
                     sda_oe <= ~sh[BYTE_W-2];
                  end
               end
               ST_RACK: begin
                  if (scl_rise && !ack_ph) begin
                     if (sda_s) begin
                        st <= ST_IDLE;
                     end else begin
                        ack_ph <= 1'b1;
                        if (idx < IDX_W'(STREAM_LEN)) idx <= idx + 1'b1;
                     end
                  end else if (scl_fall && ack_ph) begin
                     st     <= ST_TX;
                     bitcnt <= '0;
                     ack_ph <= 1'b0;
                     sh     <= tx_byte;
                     sda_oe <= ~tx_byte[BYTE_W-1];
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/kpi2c_target_chk.sv
module kpi2c_target_chk #(
   parameter int unsigned BYTE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sda_oe,
   input logic                rd_done,
   input logic [BYTE_W-1:0]   ctrl_q,
   input logic                scl_s,
   input logic                stop_det,
   input kpi2c_pkg::tgt_st_e  st
);
   import kpi2c_pkg::*;

   // R6: pulse lasts one cycle
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_done);

   // R6: pulse only comes out of the transmit phase
   a_r6_done_from_tx: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> $past(st) == ST_TX);

   // R2: control register only changes at the end of a write data byte
   a_r2_ctrl_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_q) |-> $past(st) == ST_WDATA);

   // R8: ignored write bytes never get an acknowledge
   a_r8_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_WSKIP |-> !sda_oe);

   // R10: STOP brings the target to idle with SDA released
   a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (st == ST_IDLE) && !sda_oe);

   // R11: pull-down starts only while SCL is low
   a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   // R5: idle target never holds SDA
   a_r5_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_IDLE |-> !sda_oe);

endmodule

bind kpi2c_target kpi2c_target_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sda_oe   (sda_oe),
   .rd_done  (rd_done),
   .ctrl_q   (ctrl_q),
   .scl_s    (scl_s),
   .stop_det (stop_det),
   .st       (st)
);

// File: tb/kpi2c_target_tb.sv
module kpi2c_target_tb;

   localparam logic [4:0] FIX = 5'b10110;
   localparam logic [7:0] ID  = 8'hC3;
   localparam int Q = 25;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [1:0] addr_pin = 2'b00;
   logic [7:0] key_type = 8'h5A;
   logic [7:0] key_dur  = 8'h87;
   logic       sda_oe, rd_done;
   logic [7:0] ctrl_q;
   logic       sda_bus;

   int checks = 0;
   int errors = 0;
   int done_cnt = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   kpi2c_target #(.FIX_ADDR(FIX), .CHIP_ID(ID)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_bus),
      .sda_oe   (sda_oe),
      .addr_pin (addr_pin),
      .key_type (key_type),
      .key_dur  (key_dur),
      .ctrl_q   (ctrl_q),
      .rd_done  (rd_done)
   );

   always @(posedge clk) if (rd_done) done_cnt++;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick;
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; tick;
      scl_m = 1'b1; tick;
      sda_m = 1'b0; tick;
      scl_m = 1'b0; tick;
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; tick;
      scl_m = 1'b1; tick;
      sda_m = 1'b1; tick;
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; tick;
      scl_m = 1'b1; tick; tick;
      scl_m = 1'b0; tick;
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; tick;
      scl_m = 1'b1; tick;
      b = sda_bus; tick;
      scl_m = 1'b0; tick;
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(~give_ack);
   endtask

   task automatic do_write(input logic [1:0] pins, input logic [7:0] v,
                           input string req);
      logic ack;
      bus_start;
      send_byte({FIX, pins, 1'b0}, ack);
      check({req, " address ack"}, ack, 1'b1);
      send_byte(v, ack);
      check({req, " data ack"}, ack, 1'b1);
      bus_stop;
   endtask

   task automatic t_reset;
      check("R2 reset ctrl", ctrl_q, 8'h00);
      check("R10 reset sda released", sda_oe, 1'b0);
      check("R6 reset no pulse", rd_done, 1'b0);
   endtask

   task automatic t_write_basic;
      do_write(2'b00, 8'h3C, "R1 R2");
      check("R2 ctrl loaded", ctrl_q, 8'h3C);
      check("R10 released after stop", sda_oe, 1'b0);
   endtask

   task automatic t_read_stream;
      logic ack;
      logic [7:0] v;
      int d0;
      d0 = done_cnt;
      bus_start;
      send_byte({FIX, 2'b00, 1'b1}, ack);
      check("R1 read address ack", ack, 1'b1);
      recv_byte(v, 1'b1); check("R3 chip id", v, ID);
      recv_byte(v, 1'b1); check("R3 ctrl byte", v, 8'h3C);
      recv_byte(v, 1'b1); check("R3 key type", v, 8'h5A);
      recv_byte(v, 1'b0); check("R4 duration with overflow", v, 8'h87);
      bus_stop;
      check("R6 one pulse per read", done_cnt - d0, 1);
   endtask

   task automatic t_read_nack;
      logic ack;
      logic [7:0] v;
      int d0;
      d0 = done_cnt;
      bus_start;
      send_byte({FIX, 2'b00, 1'b1}, ack);
      recv_byte(v, 1'b0);
      check("R5 id before nack", v, ID);
      recv_byte(v, 1'b0);
      check("R5 released after nack", v, 8'hFF);
      bus_stop;
      check("R5 no pulse after early nack", done_cnt - d0, 0);
   endtask

   task automatic t_bad_addr;
      logic ack;
      bus_start;
      send_byte({FIX, 2'b10, 1'b0}, ack);
      check("R1 mismatch not acked", ack, 1'b0);
      send_byte(8'h11, ack);
      check("R1 data after mismatch not acked", ack, 1'b0);
      bus_stop;
      check("R1 ctrl unchanged on mismatch", ctrl_q, 8'h3C);
   endtask

   task automatic t_pin_addr;
      addr_pin = 2'b10;
      do_write(2'b10, 8'h81, "R1 pin address");
      check("R1 ctrl via pin address", ctrl_q, 8'h81);
      addr_pin = 2'b00;
   endtask

   task automatic t_restart;
      logic ack;
      logic [7:0] v;
      bus_start;
      send_byte({FIX, 2'b00, 1'b1}, ack);
      recv_byte(v, 1'b1);
      check("R7 id before restart", v, ID);
      bus_start;
      send_byte({FIX, 2'b00, 1'b0}, ack);
      check("R7 address acked after restart", ack, 1'b1);
      send_byte(8'hC7, ack);
      check("R7 data acked after restart", ack, 1'b1);
      bus_stop;
      check("R7 ctrl after restart", ctrl_q, 8'hC7);
   endtask

   task automatic t_extra_write;
      logic ack;
      bus_start;
      send_byte({FIX, 2'b00, 1'b0}, ack);
      send_byte(8'h55, ack);
      check("R8 first data acked", ack, 1'b1);
      send_byte(8'hAA, ack);
      check("R8 second data nacked", ack, 1'b0);
      send_byte(8'h0F, ack);
      check("R8 third data nacked", ack, 1'b0);
      bus_stop;
      check("R8 ctrl keeps first byte", ctrl_q, 8'h55);
   endtask

   task automatic t_overrun;
      logic ack;
      logic [7:0] v;
      int d0;
      d0 = done_cnt;
      key_dur = 8'h13;
      bus_start;
      send_byte({FIX, 2'b00, 1'b1}, ack);
      recv_byte(v, 1'b1); check("R3 id again", v, ID);
      recv_byte(v, 1'b1); check("R3 ctrl again", v, 8'h55);
      recv_byte(v, 1'b1); check("R3 type again", v, 8'h5A);
      recv_byte(v, 1'b1); check("R4 duration no overflow", v, 8'h13);
      recv_byte(v, 1'b1); check("R9 fifth byte", v, 8'hFF);
      recv_byte(v, 1'b0); check("R9 sixth byte", v, 8'hFF);
      bus_stop;
      check("R6 single pulse with overrun", done_cnt - d0, 1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset;
      t_write_basic;
      t_read_stream;
      t_read_nack;
      t_bad_addr;
      t_pin_addr;
      t_restart;
      t_extra_write;
      t_overrun;
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule